// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block sits beside a direct-mapped primary cache and keeps a few of the lines that the primary cache has recently thrown out. It is fully associative: every entry holds a valid flag, the complete line address (tag and index together) and the line data. All entries are compared against a key in parallel. Because only evicted lines ever enter it, it catches the conflict misses that a direct-mapped cache suffers when two hot lines share an index. The primary cache's single-cycle hit path is left untouched.

The primary cache consults the buffer only after its own miss. It presents the missing line address together with the line it would displace. If the buffer holds the wanted line, the two lines trade places: the buffer's copy goes to the primary cache and the displaced line takes over the freed slot, so no memory access is needed. If the buffer misses, the primary cache later fetches the line from memory. When that fill arrives, it pushes its displaced line into the buffer through the insert port. The insert takes a free slot if one exists; otherwise it overwrites entries in rotating order. The answer to a lookup appears one cycle after the request.

Top module: `victim_line_buffer`

## Requirements
- R1: After reset every entry is empty, so any lookup answers with a miss.
- R2: A lookup whose address matches a held line raises `rsp_valid` and `rsp_hit` in the next cycle, with that line's data on `rsp_data`.
- R3: A lookup that misses raises `rsp_valid` with `rsp_hit` low in the next cycle. It leaves the stored lines unchanged, and the displaced line offered with it is not stored.
- R4: On a lookup hit with `lk_dsp_vld` high, the displaced line (address and data) replaces the hit line in the same slot. Afterwards the looked-up address misses and the displaced address hits.
- R5: On a lookup hit with `lk_dsp_vld` low, the hit slot becomes empty. A later insert fills that slot without evicting any other line.
- R6: An insert with at least one empty slot writes the lowest-numbered empty slot, so up to N distinct inserts are all kept.
- R7: An insert with all slots full overwrites the slot under a rotating pointer and moves the pointer one past it. The pointer starts at slot 0 after reset and wraps from N-1 to 0.
- R8: An insert and a lookup to the same address in one cycle answer the lookup with a hit carrying the insert data. The inserted line itself is not stored, and the displaced line, if valid, is allocated as an insert would be.
- R9: An insert in the same cycle as a lookup hit on another address performs both. When the buffer is full and the pointer sits on the hit slot, the insert takes the slot after it, and the pointer moves one past that slot.
- R10: In a cycle without a lookup request, the following cycle shows `rsp_valid` and `rsp_hit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request after a primary-cache miss |
| lk_addr | input | AW | Full line address being looked up |
| lk_dsp_vld | input | 1 | The primary line displaced by a hit is valid |
| lk_dsp_addr | input | AW | Line address of the displaced primary line |
| lk_dsp_data | input | DW | Data of the displaced primary line |
| ins_req | input | 1 | Insert a line evicted by a memory fill |
| ins_addr | input | AW | Line address to insert |
| ins_data | input | DW | Line data to insert |
| rsp_valid | output | 1 | A lookup answer is present (one cycle after `lk_req`) |
| rsp_hit | output | 1 | The answered lookup hit |
| rsp_data | output | DW | Line data for a hit |

## Verification
The assertions assume that the primary cache never offers a line the buffer already holds. An inserted address is therefore absent from the buffer, and a displaced address is absent from the buffer and differs from both the lookup and insert addresses of the same cycle. Under that assumption, stored addresses stay unique, a swapped-out address disappears and a swapped-in one appears. The stimulus draws addresses from a small shared pool to force frequent hits, rotation and concurrent operations. Before each cycle it checks its reference model and drops any insert or displaced address that would violate the assumption.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

  // Source of the line allocated into the buffer in a given cycle.
  typedef enum logic [1:0] {
    ALC_NONE      = 2'd0,
    ALC_FILL      = 2'd1,
    ALC_DISPLACED = 2'd2
  } alloc_src_e;

endpackage

// File: rtl/vlb_match.sv
module vlb_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]         ent_vld,
  input  logic [N-1:0][AW-1:0] ent_addr,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic [IW-1:0]        hit_idx
);

  // One comparator per entry, all in parallel.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_addr[g] == key);
  end

  // Encode the matching slot; at most one matches while addresses stay unique.
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

endmodule

// File: rtl/vlb_alloc.sv
module vlb_alloc #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [N-1:0]  ent_vld,
  input  logic          skip_en,
  input  logic [IW-1:0] skip_idx,
  input  logic          take,
  output logic [IW-1:0] slot
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rot_idx;
  logic          full;

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] v);
    return (v == IW'(N - 1)) ? '0 : v + 1'b1;
  endfunction

  assign full = &ent_vld;

  // Lowest-numbered empty slot.
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IW'(i);
    end
  end

  // Rotating choice, stepping over a slot that a swap writes this cycle.
  always_comb begin
    rot_idx = ptr_q;
    if (skip_en && (ptr_q == skip_idx)) rot_idx = step_idx(ptr_q);
  end

  assign slot = full ? rot_idx : free_idx;

  always_comb begin
    ptr_d = ptr_q;
    if (take && full) ptr_d = step_idx(rot_idx);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

endmodule

// File: rtl/vlb_store.sv
module vlb_store #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  parameter int unsigned DW = 64,
  parameter int unsigned IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  // swap port: rewrites the hit slot
  input  logic                 a_we,
  input  logic [IW-1:0]        a_idx,
  input  logic                 a_vld,
  input  logic [AW-1:0]        a_addr,
  input  logic [DW-1:0]        a_data,
  // allocation port: writes a chosen slot with a valid line
  input  logic                 b_we,
  input  logic [IW-1:0]        b_idx,
  input  logic [AW-1:0]        b_addr,
  input  logic [DW-1:0]        b_data,
  output logic [N-1:0]         ent_vld,
  output logic [N-1:0][AW-1:0] ent_addr,
  output logic [N-1:0][DW-1:0] ent_data
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic          sel_a, sel_b;
    logic          vld_d;
    logic          line_en;
    logic [AW-1:0] addr_d;
    logic [DW-1:0] data_d;

    assign sel_a = a_we && (a_idx == IW'(g));
    assign sel_b = b_we && (b_idx == IW'(g));

    always_comb begin
      vld_d   = ent_vld[g];
      addr_d  = ent_addr[g];
      data_d  = ent_data[g];
      line_en = 1'b0;
      if (sel_b) begin
        vld_d   = 1'b1;
        addr_d  = b_addr;
        data_d  = b_data;
        line_en = 1'b1;
      end else if (sel_a) begin
        vld_d   = a_vld;
        addr_d  = a_addr;
        data_d  = a_data;
        line_en = a_vld;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ent_vld[g] <= 1'b0;
      else         ent_vld[g] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (line_en) begin
        ent_addr[g] <= addr_d;
        ent_data[g] <= data_d;
      end
    end
  end

endmodule

// File: rtl/victim_line_buffer.sv
module victim_line_buffer #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_req,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_dsp_vld,
  input  logic [AW-1:0] lk_dsp_addr,
  input  logic [DW-1:0] lk_dsp_data,
  input  logic          ins_req,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data
);
  import vlb_pkg::*;

  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [N-1:0]         ent_vld;
  logic [N-1:0][AW-1:0] ent_addr;
  logic [N-1:0][DW-1:0] ent_data;
  logic [N-1:0]         hit_vec;
  logic [IW-1:0]        m_idx;
  logic                 m_hit;
  logic                 bypass;
  logic                 swap_we;
  alloc_src_e           al_src;
  logic [AW-1:0]        al_addr;
  logic [DW-1:0]        al_data;
  logic                 al_take;
  logic [IW-1:0]        al_slot;

  vlb_match #(.N(N), .AW(AW), .IW(IW)) u_match (
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .key      (lk_addr),
    .hit_vec  (hit_vec),
    .hit_idx  (m_idx)
  );

  assign m_hit   = |hit_vec;
  assign bypass  = lk_req && ins_req && (lk_addr == ins_addr);
  assign swap_we = lk_req && m_hit && !bypass;

  // Which line, if any, needs a fresh slot this cycle.
  always_comb begin
    al_src  = ALC_NONE;
    al_addr = ins_addr;
    al_data = ins_data;
    if (bypass) begin
      if (lk_dsp_vld) al_src = ALC_DISPLACED;
      al_addr = lk_dsp_addr;
      al_data = lk_dsp_data;
    end else if (ins_req) begin
      al_src = ALC_FILL;
    end
  end
  assign al_take = (al_src != ALC_NONE);

  vlb_alloc #(.N(N), .IW(IW)) u_alloc (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .ent_vld  (ent_vld),
    .skip_en  (swap_we),
    .skip_idx (m_idx),
    .take     (al_take),
    .slot     (al_slot)
  );

  vlb_store #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_store (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .a_we     (swap_we),
    .a_idx    (m_idx),
    .a_vld    (lk_dsp_vld),
    .a_addr   (lk_dsp_addr),
    .a_data   (lk_dsp_data),
    .b_we     (al_take),
    .b_idx    (al_slot),
    .b_addr   (al_addr),
    .b_data   (al_data),
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .ent_data (ent_data)
  );

  // Response stage.
  logic          rsp_valid_d, rsp_hit_d;
  logic [DW-1:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = lk_req;
    rsp_hit_d   = lk_req && (bypass || m_hit);
    rsp_data_d  = bypass ? ins_data : ent_data[m_idx];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) rsp_data <= rsp_data_d;
  end

endmodule

// File: rtl/vlb_checker.sv
module vlb_checker #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 lk_req,
  input logic [AW-1:0]        lk_addr,
  input logic                 lk_dsp_vld,
  input logic [AW-1:0]        lk_dsp_addr,
  input logic                 ins_req,
  input logic [AW-1:0]        ins_addr,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [N-1:0]         ent_vld,
  input logic [N-1:0][AW-1:0] ent_addr,
  input logic [N-1:0]         hit_vec
);

  function automatic logic holds(input logic [N-1:0] v,
                                 input logic [N-1:0][AW-1:0] a,
                                 input logic [AW-1:0] k);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++) if (v[i] && a[i] == k) r = 1'b1;
    return r;
  endfunction

  logic same_cyc;
  int   dup_cnt;

  assign same_cyc = lk_req && ins_req && (lk_addr == ins_addr);

  always_comb begin
    dup_cnt = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (ent_vld[i] && ent_vld[j] && ent_addr[i] == ent_addr[j]) dup_cnt++;
  end

  // R6: stored line addresses never repeat
  p_unique_lines_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    dup_cnt == 0);

  // R2: at most one slot matches a key
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R10: a hit is only reported alongside a response
  p_hit_needs_rsp_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_hit |-> rsp_valid);

  // R6: an ordinary insert is held afterwards
  p_fill_kept_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ins_req && !same_cyc) |=> holds(ent_vld, ent_addr, $past(ins_addr)));

  // R4: the hit line leaves the buffer
  p_swap_out_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_req && (|hit_vec) && !same_cyc) |=> !holds(ent_vld, ent_addr, $past(lk_addr)));

  // R4: the displaced line enters the buffer
  p_swap_in_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_req && (|hit_vec) && lk_dsp_vld && !same_cyc)
      |=> holds(ent_vld, ent_addr, $past(lk_dsp_addr)));

  // R7: a full buffer stays full unless a hit frees a slot
  p_full_stays_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((&ent_vld) && !(lk_req && (|hit_vec) && !lk_dsp_vld)) |=> (&ent_vld));

endmodule

bind victim_line_buffer vlb_checker #(.N(N), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .lk_req      (lk_req),
  .lk_addr     (lk_addr),
  .lk_dsp_vld  (lk_dsp_vld),
  .lk_dsp_addr (lk_dsp_addr),
  .ins_req     (ins_req),
  .ins_addr    (ins_addr),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .ent_vld     (ent_vld),
  .ent_addr    (ent_addr),
  .hit_vec     (hit_vec)
);

// File: tb/victim_line_buffer_tb.sv
module victim_line_buffer_tb;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_req = 1'b0, lk_dsp_vld = 1'b0, ins_req = 1'b0;
  logic [AW-1:0] lk_addr = '0, lk_dsp_addr = '0, ins_addr = '0;
  logic [DW-1:0] lk_dsp_data = '0, ins_data = '0;
  logic          rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  victim_line_buffer #(.N(N), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_dsp_vld(lk_dsp_vld), .lk_dsp_addr(lk_dsp_addr), .lk_dsp_data(lk_dsp_data),
    .ins_req(ins_req), .ins_addr(ins_addr), .ins_data(ins_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
  );

  // Reference model: slot contents plus rotation pointer, per the requirements.
  bit            mv [N];
  logic [AW-1:0] ma [N];
  logic [DW-1:0] md [N];
  int            mptr;

  function automatic bit mholds(logic [AW-1:0] k);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == k) return 1;
    return 0;
  endfunction

  function automatic logic [AW-1:0] ad(int i); return AW'(32'h0A0 + i); endfunction
  function automatic logic [DW-1:0] dt(int i); return {32'hD00D0000 + i, 32'h5A5A0000 ^ i}; endfunction

  task automatic step(input string tag,
                      input bit lk, input logic [AW-1:0] la,
                      input bit dv, input logic [AW-1:0] da, input logic [DW-1:0] dd,
                      input bit ins, input logic [AW-1:0] ia, input logic [DW-1:0] id);
    bit ev, eh, byp, aen, full;
    logic [DW-1:0] ed;
    logic [AW-1:0] aa;
    logic [DW-1:0] adat;
    int h, s;
    lk_req = lk; lk_addr = la; lk_dsp_vld = dv; lk_dsp_addr = da; lk_dsp_data = dd;
    ins_req = ins; ins_addr = ia; ins_data = id;
    @(posedge clk);
    byp = lk && ins && (la == ia);
    h = -1;
    if (lk && !byp) for (int i = 0; i < N; i++) if (mv[i] && ma[i] == la) h = i;
    ev = lk; eh = byp || (h >= 0);
    ed = byp ? id : ((h >= 0) ? md[h] : '0);
    aen = 0; aa = ia; adat = id;
    if (byp) begin aen = dv; aa = da; adat = dd; end
    else if (ins) aen = 1;
    full = 1; s = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin full = 0; s = i; end
    if (full) begin
      s = mptr;
      if (h >= 0 && s == h) s = (s + 1) % N;
    end
    if (h >= 0) begin mv[h] = dv; ma[h] = da; md[h] = dd; end
    if (aen) begin
      mv[s] = 1; ma[s] = aa; md[s] = adat;
      if (full) mptr = (s + 1) % N;
    end
    @(negedge clk);
    checks++;
    if (rsp_valid !== ev || rsp_hit !== eh || (eh && rsp_data !== ed)) begin
      bad++;
      $display("FAIL %s: valid/hit/data got %0b/%0b/%h expected %0b/%0b/%h",
               tag, rsp_valid, rsp_hit, rsp_data, ev, eh, ed);
    end
  endtask

  task automatic look(string tag, int a, bit dv, int d);
    step(tag, 1, ad(a), dv, ad(d), dt(d), 0, '0, '0);
  endtask

  task automatic put(string tag, int a);
    step(tag, 0, '0, 0, '0, '0, 1, ad(a), dt(a));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = '0; md[i] = '0; end
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 idle, R1 empty after reset
    step("R10", 0, '0, 0, '0, '0, 0, '0, '0);
    look("R1", 0, 0, 0);
    look("R1", 3, 1, 20);
    // R6 fill all slots
    for (int i = 0; i < 4; i++) put("R6", i);
    // R2/R4 swap and swap back
    look("R2", 2, 1, 8);
    look("R4", 8, 1, 2);
    look("R4", 2, 1, 9);
    look("R4", 9, 1, 2);
    // R3 miss leaves contents alone
    look("R3", 10, 1, 11);
    look("R3", 11, 0, 0);
    // R7 rotation on full
    put("R7", 4);
    look("R7", 0, 0, 0);
    put("R7", 5);
    look("R7", 1, 0, 0);
    // R5 hit with empty displacement frees a slot
    look("R5", 3, 0, 0);
    put("R5", 6);
    look("R5", 4, 1, 12);
    look("R5", 5, 1, 13);
    look("R5", 2, 1, 14);
    // R8 same-cycle insert and lookup
    step("R8", 1, ad(7), 1, ad(15), dt(15), 1, ad(7), dt(7));
    look("R8", 15, 1, 16);
    look("R8", 7, 0, 0);
    // R9 hit plus insert in one cycle (buffer full)
    step("R9", 1, ad(12), 1, ad(17), dt(17), 1, ad(18), dt(18));
    look("R9", 17, 1, 19);
    look("R9", 18, 1, 21);
    step("R10", 0, '0, 0, '0, '0, 0, '0, '0);

    // R2 mixed traffic over a small address pool
    for (int n = 0; n < 600; n++) begin
      bit lk, dv, ins;
      int la, da, ia, st;
      lk = ($urandom % 2) == 0;
      la = 40 + ($urandom % 8);
      ins = ($urandom % 5) < 2;
      ia = -1;
      if (ins) begin
        st = $urandom % 8;
        for (int k = 0; k < 8; k++)
          if (ia < 0 && !mholds(ad(40 + (st + k) % 8))) ia = 40 + (st + k) % 8;
        if (ia < 0) ins = 0;
        else if (lk && ($urandom % 4) == 0) la = ia;
      end
      dv = ($urandom % 5) < 3;
      da = -1;
      if (dv) begin
        st = $urandom % 8;
        for (int k = 0; k < 8; k++) begin
          int c;
          c = 40 + (st + k) % 8;
          if (da < 0 && !mholds(ad(c)) && c != la && c != ia) da = c;
        end
        if (da < 0) begin dv = 0; da = 0; end
      end else da = 0;
      if (ia < 0) ia = 0;
      step("R2", lk, ad(la), dv, ad(da), dt(da + 100 * n), ins, ad(ia), dt(ia + 7 * n));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule